// File: doc/BRIEF.md
# Parallel Flash Command and Completion Sequencer

This block sits on the host side of a byte-wide parallel flash and turns one request into a complete bus conversation. A request asks for one of three jobs: write a single byte, clear one 4 KiB sector, or clear the whole array. The block then drives the unlock and command writes, one bus operation per clock. After the write that starts the internal job, it reads the target location until status bit 7 shows completion or a poll budget runs out.

A status bit can flip at the same moment a poll samples it, so the block never trusts one read. Once bit 7 shows completion, it reads the location twice more. It reports success only if both reads return the full expected byte: the written data for a byte write, all ones for an erase.

The request side is a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold its fields stable until that edge. `req_ready` is high only when the block is idle. The result is a one-cycle `rsp_valid` pulse carrying a code, with no back-pressure. The flash model answers reads in the same cycle as `fl_oe`.

Top module: `flash_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `fl_we`, `fl_oe`, `fl_cs` and `rsp_valid` are 0.
- R2: For op 00 (byte write), the cycles after acceptance carry four writes, one per cycle, as address/data pairs: 5555h/AAh, 2AAAh/55h, 5555h/A0h, then the request address with the request data.
- R3: For op 01 (sector erase), six writes: 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, then the address with bits 11..0 cleared (bits 17..12 select the sector) with data 30h.
- R4: For op 10 (chip erase), the same first five writes as R3, then 5555h/10h.
- R5: Reads begin in the cycle right after the last write. They target the request address for a byte write, the sector base for a sector erase, and 5555h for a chip erase.
- R6: A poll shows completion when read bit 7 equals bit 7 of the written data (byte write) or equals 1 (erase). Otherwise polling continues in the next cycle.
- R7: After a completing poll, two confirming reads of the same location follow in the next two cycles. Success needs both to equal the full expected byte: the data for a byte write, FFh for an erase. A completing poll whose lower bits are wrong is not an error.
- R8: If the first confirming read mismatches, the response is code 01 (error) in the next cycle, with no second confirming read. A mismatch on the second read also gives code 01.
- R9: If POLL_LIMIT polls pass without completion, the response is code 10 (timeout) in the cycle after the last poll.
- R10: `rsp_valid` is high for exactly one cycle, in the cycle after the last read. Code 00 means success.
- R11: `req_ready` is low from the acceptance edge through the response cycle. Requests presented in that window are not taken and do not alter the bus traffic.
- R12: Op 11 is answered with code 01 in the cycle after acceptance, with no bus operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_op | input | 2 | 00 byte write, 01 sector erase, 10 chip erase, 11 reserved |
| req_addr | input | ADDR_W | Target byte address |
| req_data | input | DATA_W | Byte to write |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_code | output | 2 | 00 ok, 01 error, 10 timeout |
| fl_cs | output | 1 | Flash select, high during any bus operation |
| fl_we | output | 1 | Write operation this cycle |
| fl_oe | output | 1 | Read operation this cycle |
| fl_addr | output | ADDR_W | Flash address |
| fl_wdata | output | DATA_W | Write data |
| fl_rdata | input | DATA_W | Read data, valid in the `fl_oe` cycle |

## Verification
If a request is accepted at edge E, write k of its sequence appears in cycle E+k. The first poll follows the last write at once. If the flash stays busy for B polls, the completing poll comes B+1 cycles after the last write, then the two confirming reads, then the response. A timeout response appears exactly POLL_LIMIT cycles after the last write plus one. The bench builds this whole cycle list in a queue at acceptance, from the request and the flash model's busy length. It then compares every output against the front of the queue at each falling edge, so any early, late, missing or extra cycle shows up as a mismatch.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'b00,
    OP_SECT = 2'b01,
    OP_CHIP = 2'b10,
    OP_RSVD = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    RC_OK  = 2'b00,
    RC_ERR = 2'b01,
    RC_TMO = 2'b10
  } rc_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CMD,
    S_POLL,
    S_CHK1,
    S_CHK2,
    S_RESP
  } st_e;
endpackage

// File: rtl/flash_seq_cmdgen.sv
module flash_seq_cmdgen
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 8,
  parameter int SECT_LSB = 12
) (
  input  op_e               op,
  input  logic [2:0]        step,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              last,
  output logic [ADDR_W-1:0] poll_addr
);
  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(18'h05555);
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(18'h02AAA);
  localparam logic [ADDR_W-1:0] SECT_MASK =
    ~((ADDR_W'(1) << SECT_LSB) - ADDR_W'(1));

  logic [ADDR_W-1:0] sect_base;
  assign sect_base = addr & SECT_MASK;

  always_comb begin
    case (op)
      OP_PROG: poll_addr = addr;
      OP_SECT: poll_addr = sect_base;
      default: poll_addr = A_HI;
    endcase
  end

  always_comb begin
    wr_addr = A_HI;
    wr_data = DATA_W'(8'hAA);
    last    = 1'b0;
    case (step)
      3'd0: begin wr_addr = A_HI; wr_data = DATA_W'(8'hAA); end
      3'd1: begin wr_addr = A_LO; wr_data = DATA_W'(8'h55); end
      3'd2: begin
        wr_addr = A_HI;
        wr_data = (op == OP_PROG) ? DATA_W'(8'hA0) : DATA_W'(8'h80);
      end
      3'd3: begin
        if (op == OP_PROG) begin
          wr_addr = addr;
          wr_data = data;
          last    = 1'b1;
        end else begin
          wr_addr = A_HI;
          wr_data = DATA_W'(8'hAA);
        end
      end
      3'd4: begin wr_addr = A_LO; wr_data = DATA_W'(8'h55); end
      default: begin
        last = 1'b1;
        if (op == OP_SECT) begin
          wr_addr = sect_base;
          wr_data = DATA_W'(8'h30);
        end else begin
          wr_addr = A_HI;
          wr_data = DATA_W'(8'h10);
        end
      end
    endcase
  end
endmodule

// File: rtl/flash_seq_status.sv
module flash_seq_status
  import flash_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] wdata,
  output logic              done,
  output logic              match
);
  logic [DATA_W-1:0] expect_q;

  assign expect_q = (op == OP_PROG) ? wdata : {DATA_W{1'b1}};
  assign done     = (rdata[DATA_W-1] == expect_q[DATA_W-1]);
  assign match    = (rdata == expect_q);
endmodule

// File: rtl/flash_seq_poll_timer.sv
module flash_seq_poll_timer #(
  parameter int LIMIT = 7500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (tick)  cnt <= cnt + CW'(1);
  end

  assign expired = tick && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 8,
  parameter int SECT_LSB   = 12,
  parameter int POLL_LIMIT = 7500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic              fl_cs,
  output logic              fl_we,
  output logic              fl_oe,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_wdata,
  input  logic [DATA_W-1:0] fl_rdata
);
  st_e               state;
  op_e               op_q;
  logic [2:0]        step;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  rc_e               rc_q;

  logic [ADDR_W-1:0] wr_addr, poll_addr;
  logic [DATA_W-1:0] wr_data;
  logic              last, done, match, expired;

  flash_seq_cmdgen #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_LSB(SECT_LSB)
  ) u_cmd (
    .op(op_q), .step(step), .addr(addr_q), .data(data_q),
    .wr_addr(wr_addr), .wr_data(wr_data), .last(last), .poll_addr(poll_addr)
  );

  flash_seq_status #(.DATA_W(DATA_W)) u_stat (
    .op(op_q), .rdata(fl_rdata), .wdata(data_q), .done(done), .match(match)
  );

  flash_seq_poll_timer #(.LIMIT(POLL_LIMIT)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .clear(state == S_CMD), .tick(state == S_POLL), .expired(expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      op_q   <= OP_PROG;
      step   <= '0;
      addr_q <= '0;
      data_q <= '0;
      rc_q   <= RC_OK;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          op_q   <= op_e'(req_op);
          addr_q <= req_addr;
          data_q <= req_data;
          step   <= '0;
          if (op_e'(req_op) == OP_RSVD) begin
            rc_q  <= RC_ERR;
            state <= S_RESP;
          end else begin
            state <= S_CMD;
          end
        end
        S_CMD: begin
          if (last) state <= S_POLL;
          else      step  <= step + 3'd1;
        end
        S_POLL: begin
          if (done) begin
            state <= S_CHK1;
          end else if (expired) begin
            rc_q  <= RC_TMO;
            state <= S_RESP;
          end
        end
        S_CHK1: begin
          if (match) begin
            state <= S_CHK2;
          end else begin
            rc_q  <= RC_ERR;
            state <= S_RESP;
          end
        end
        S_CHK2: begin
          rc_q  <= match ? RC_OK : RC_ERR;
          state <= S_RESP;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign fl_we     = (state == S_CMD);
  assign fl_oe     = (state == S_POLL) || (state == S_CHK1) || (state == S_CHK2);
  assign fl_cs     = fl_we || fl_oe;
  assign fl_addr   = fl_we ? wr_addr : (fl_oe ? poll_addr : '0);
  assign fl_wdata  = fl_we ? wr_data : '0;
  assign rsp_valid = (state == S_RESP);
  assign rsp_code  = rc_q;
endmodule

// File: rtl/flash_seq_checker.sv
module flash_seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic [1:0] rsp_code,
  input logic       fl_we,
  input logic       fl_oe
);
  a_r11_busy_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we || fl_oe || rsp_valid) |-> !req_ready);

  a_r2_bus_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_oe));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r11_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r5_poll_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_oe) |-> $past(fl_we));

  a_r9_timeout_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 2'b10) |-> $past(fl_oe));
endmodule

bind flash_seq flash_seq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_code(rsp_code), .fl_we(fl_we), .fl_oe(fl_oe)
);

// File: tb/test_flash_seq.sv
`timescale 1ns/1ps
module test_flash_seq;
  localparam int LIM = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'b00;
  logic [17:0] req_addr = '0;
  logic [7:0]  req_data = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic        fl_cs, fl_we, fl_oe;
  logic [17:0] fl_addr;
  logic [7:0]  fl_wdata;
  logic [7:0]  fl_rdata;

  always #2 clk = ~clk;

  flash_seq #(.POLL_LIMIT(LIM)) i_flash_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .fl_cs(fl_cs), .fl_we(fl_we),
    .fl_oe(fl_oe), .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata)
  );

  // Behavioural flash: busy for m_busy reads after the last command write.
  int       m_len = 4, m_wcnt = 0, m_left = 0;
  bit       m_prog = 1'b1, m_glitch = 1'b0;
  bit [7:0] m_val = 8'hFF;

  always @(posedge clk) begin
    if (m_left > 0) m_left <= m_left - 1;
    if (fl_oe && m_left == 0 && m_glitch) m_glitch <= 1'b0;
    if (fl_we) begin
      if (m_wcnt + 1 == m_len) m_wcnt <= 0;
      else                     m_wcnt <= m_wcnt + 1;
    end
  end

  int m_busy = 0;
  always @(posedge clk) if (fl_we && m_wcnt + 1 == m_len) m_left <= m_busy;

  always_comb begin
    if (m_left > 0)  fl_rdata = m_prog ? {~m_val[7], 7'h2A} : 8'h55;
    else if (m_glitch) fl_rdata = m_prog ? {m_val[7], ~m_val[6:0]} : 8'h80;
    else             fl_rdata = m_val;
  end

  typedef struct packed {
    bit we; bit oe; bit [17:0] a; bit [7:0] d; bit rv; bit [1:0] rc;
  } cyc_t;
  cyc_t  q[$];
  string tq[$];
  int n_cmp = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    cyc_t  e;
    string t;
    bit    rdy;
    rdy = (q.size() == 0);
    if (rdy) begin e = '0; t = "R11"; end
    else begin e = q.pop_front(); t = tq.pop_front(); end
    chk(req_ready == rdy, "R11", "req_ready", int'(req_ready), int'(rdy));
    chk(fl_we == e.we, t, "fl_we", int'(fl_we), int'(e.we));
    chk(fl_oe == e.oe, t, "fl_oe", int'(fl_oe), int'(e.oe));
    chk(fl_cs == (e.we | e.oe), t, "fl_cs", int'(fl_cs), int'(e.we | e.oe));
    if (e.we | e.oe) chk(fl_addr == e.a, t, "fl_addr", int'(fl_addr), int'(e.a));
    if (e.we) chk(fl_wdata == e.d, t, "fl_wdata", int'(fl_wdata), int'(e.d));
    chk(rsp_valid == e.rv, t, "rsp_valid", int'(rsp_valid), int'(e.rv));
    if (e.rv) chk(rsp_code == e.rc, t, "rsp_code", int'(rsp_code), int'(e.rc));
  end

  task automatic push(input bit we, oe, input bit [17:0] a, input bit [7:0] d,
                      input bit rv, input bit [1:0] rc, input string t);
    cyc_t c;
    c.we = we; c.oe = oe; c.a = a; c.d = d; c.rv = rv; c.rc = rc;
    q.push_back(c);
    tq.push_back(t);
  endtask

  task automatic run(input bit [1:0] op, input bit [17:0] a, input bit [7:0] d,
                     input int busy, input bit glitch, input bit stuck, input bit junk);
    bit [17:0] pa;
    bit [7:0]  ex, mv;
    string     wt;
    @(negedge clk); #1;
    m_prog = (op == 2'b00); m_len = (op == 2'b00) ? 4 : 6; m_wcnt = 0;
    m_busy = busy; m_glitch = glitch;
    ex = (op == 2'b00) ? d : 8'hFF;
    mv = stuck ? (ex & 8'hFE) : ex;
    m_val = mv;
    req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
    if (op == 2'b11) begin
      push(0, 0, 0, 0, 1, 2'b01, "R12");
    end else begin
      wt = (op == 2'b00) ? "R2" : (op == 2'b01) ? "R3" : "R4";
      pa = (op == 2'b00) ? a : (op == 2'b01) ? {a[17:12], 12'h000} : 18'h05555;
      push(1, 0, 18'h05555, 8'hAA, 0, 0, wt);
      push(1, 0, 18'h02AAA, 8'h55, 0, 0, wt);
      if (op == 2'b00) begin
        push(1, 0, 18'h05555, 8'hA0, 0, 0, wt);
        push(1, 0, a, d, 0, 0, wt);
      end else begin
        push(1, 0, 18'h05555, 8'h80, 0, 0, wt);
        push(1, 0, 18'h05555, 8'hAA, 0, 0, wt);
        push(1, 0, 18'h02AAA, 8'h55, 0, 0, wt);
        if (op == 2'b01) push(1, 0, pa, 8'h30, 0, 0, wt);
        else             push(1, 0, 18'h05555, 8'h10, 0, 0, wt);
      end
      if (busy >= LIM) begin
        for (int i = 0; i < LIM; i++) push(0, 1, pa, 0, 0, 0, "R9");
        push(0, 0, 0, 0, 1, 2'b10, "R9");
      end else begin
        for (int i = 0; i < busy; i++) push(0, 1, pa, 0, 0, 0, "R5");
        push(0, 1, pa, 0, 0, 0, "R6");
        push(0, 1, pa, 0, 0, 0, "R7");
        if (mv == ex) begin
          push(0, 1, pa, 0, 0, 0, "R7");
          push(0, 0, 0, 0, 1, 2'b00, "R10");
        end else begin
          push(0, 0, 0, 0, 1, 2'b01, "R8");
        end
      end
    end
    @(negedge clk); #1;
    if (junk) begin
      req_op = 2'b10; req_addr = 18'h3FFFF; req_data = 8'h00;
      while (q.size() != 0) begin @(negedge clk); #1; end
    end
    req_valid = 1'b0;
    while (q.size() != 0) begin @(negedge clk); #1; end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "reset req_ready", int'(req_ready), 1);
    chk(!fl_we && !fl_oe && !fl_cs, "R1", "reset bus idle",
        int'({fl_we, fl_oe, fl_cs}), 0);
    chk(rsp_valid == 1'b0, "R1", "reset rsp_valid", int'(rsp_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(2'b00, 18'h12345, 8'h5A, 3, 0, 0, 1);   // R2 R11 junk held high
    run(2'b00, 18'h00001, 8'hC3, 0, 0, 0, 0);   // R6 dq7 = 1 data
    run(2'b01, 18'h3F123, 8'h00, 5, 0, 0, 0);   // R3 sector base
    run(2'b10, 18'h00000, 8'h00, 2, 0, 0, 0);   // R4
    run(2'b00, 18'h2AB00, 8'h37, 2, 1, 0, 0);   // R7 race on done poll
    run(2'b01, 18'h01FFF, 8'h00, 1, 1, 0, 0);   // R7 erase race
    run(2'b00, 18'h00400, 8'h81, 1, 0, 1, 0);   // R8 stuck bit
    run(2'b00, 18'h00400, 8'h11, LIM, 0, 0, 0); // R9 timeout
    run(2'b00, 18'h00402, 8'h22, LIM - 1, 0, 0, 0); // R9 boundary, still ok
    run(2'b11, 18'h00000, 8'h00, 0, 0, 0, 1);   // R12 reserved op
    run(2'b10, 18'h00000, 8'h00, 0, 0, 0, 0);   // R4 R6 immediate done
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R10 watchdog: actual hung expected response");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule